// File: doc/BRIEF.md
# Coupling-Safe Bus Codec

This block sits at both ends of a long parallel on-chip bus. It rewrites each data word so that no three neighbouring wires ever carry 010 or 101. Those are the only patterns in which a middle wire can see both neighbours switch against it. With them gone, the worst-case coupling load on any wire drops, so the bus can run faster.

The word is cut into 4-bit groups. Each group is looked up in a 16-entry book of 5-bit words that contain no forbidden window. A later group may then be inverted so that its first wire repeats the last wire of the group below it, which keeps the windows that straddle a boundary clean. Each inversion choice depends on the group before it. One register stage per group resolves these choices in order, so no combinational chain runs across the word. A polarity sideband tells the receiving side which groups were inverted. The decoder undoes the inversion and the book lookup, and returns the original word.

The top module joins the encoder to the decoder through the encoded bus. The encoded wires and the polarity bits are brought out as ports.

Top module: `xtc_codec`

## Requirements
- R1: A group value v (0 to 15) maps to the (v+1)-th smallest 5-bit word free of 010 and 101, giving 00000, 00001, 00011, 00110, 00111, 01100, 01110, 01111, 10000, 10001, 10011, 11000, 11001, 11100, 11110, 11111. Data group g is in_data[4g+3:4g]. Code group g is bus_wires[5g+4:5g], and wire 5g is the first wire of that group.
- R2: Whenever bus_valid is high, no three adjacent wires of bus_wires hold 010 or 101. This covers the windows that cross a group boundary.
- R3: Group 0 is always sent uninverted, and bus_pol[0] is 0.
- R4: For g > 0, group g is sent bitwise inverted exactly when the lowest bit of its code word differs from wire 5g-1 as transmitted. bus_pol[g] is 1 exactly when group g is inverted.
- R5: A word sampled with in_valid high appears on bus_wires and bus_pol, with bus_valid high, right after the NGRP-th rising edge, counting the edge that sampled it. NGRP is DATA_W/4. The block accepts one word on every cycle and keeps the words in order.
- R6: dec_valid rises one cycle after bus_valid, and dec_data then equals the word that was sent.
- R7: While rst is high at a clock edge, every output register clears: bus_valid, dec_valid, bus_wires, bus_pol and dec_data all read 0.
- R8: A cycle with in_valid low produces no output word. The data on in_data in that cycle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | DATA_W | Word to transmit |
| bus_valid | output | 1 | Encoded bus word is valid |
| bus_wires | output | 5*DATA_W/4 | Encoded bus wires |
| bus_pol | output | DATA_W/4 | Per-group inversion flags |
| dec_valid | output | 1 | Decoded word is valid |
| dec_data | output | DATA_W | Recovered word |

## Verification
The first stimulus walks all sixteen group values, with the same value copied into every group. This pins down the code book and shows whether a repeated code chains cleanly or needs inversion at each boundary. A sweep of all 256 value pairs in the two lowest groups reaches every boundary case: matching edge bits, mismatched edge bits, and a lower group that was itself inverted. Random words with random idle gaps then separate correct pipelining and bubble handling from a design that only works on back-to-back traffic. Every output word is compared against an independent model of the inversion rule, its latency stamp and a window scan.

// File: rtl/xtc_pkg.sv
package xtc_pkg;
  localparam int GRP_W  = 4;
  localparam int CODE_W = 5;

  function automatic logic win_clean5(input logic [CODE_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < CODE_W - 2; i++) begin
      if (w[i +: 3] == 3'b010 || w[i +: 3] == 3'b101) ok = 1'b0;
    end
    return ok;
  endfunction

  function automatic logic [CODE_W-1:0] grp_encode(input logic [GRP_W-1:0] v);
    logic [CODE_W-1:0] res;
    int n;
    res = '0;
    n = 0;
    for (int c = 0; c < (1 << CODE_W); c++) begin
      if (win_clean5(CODE_W'(c))) begin
        if (n == int'(v)) res = CODE_W'(c);
        n++;
      end
    end
    return res;
  endfunction

  function automatic logic [GRP_W-1:0] grp_decode(input logic [CODE_W-1:0] code);
    logic [GRP_W-1:0] res;
    int n;
    res = '0;
    n = 0;
    for (int c = 0; c < (1 << CODE_W); c++) begin
      if (win_clean5(CODE_W'(c))) begin
        if (CODE_W'(c) == code) res = GRP_W'(n);
        n++;
      end
    end
    return res;
  endfunction
endpackage

// File: rtl/xtc_encoder.sv
module xtc_encoder
  import xtc_pkg::*;
#(
  parameter int NGRP = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [NGRP*GRP_W-1:0]  in_data,
  output logic                   out_valid,
  output logic [NGRP*CODE_W-1:0] out_wires,
  output logic [NGRP-1:0]        out_pol
);
  localparam int BUS_W = NGRP * CODE_W;

  logic [BUS_W-1:0] raw_code;
  logic [BUS_W-1:0] st_w [NGRP];
  logic [NGRP-1:0]  st_p [NGRP];
  logic [NGRP-1:0]  st_v;
  logic [NGRP-1:0]  flip;
  logic [BUS_W-1:0] fmask [NGRP];

  for (genvar g = 0; g < NGRP; g++) begin : g_lut
    assign raw_code[g*CODE_W +: CODE_W] = grp_encode(in_data[g*GRP_W +: GRP_W]);
  end

  // Stage s settles group s; groups below it are already final in stage s-1.
  always_comb begin
    flip[0]  = 1'b0;
    fmask[0] = '0;
    for (int s = 1; s < NGRP; s++) begin
      flip[s]  = st_w[s-1][s*CODE_W-1] ^ st_w[s-1][s*CODE_W];
      fmask[s] = '0;
      fmask[s][s*CODE_W +: CODE_W] = {CODE_W{flip[s]}};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_v <= '0;
      for (int s = 0; s < NGRP; s++) begin
        st_w[s] <= '0;
        st_p[s] <= '0;
      end
    end else begin
      st_v[0]    <= in_valid;
      st_w[0]    <= raw_code ^ fmask[0];
      st_p[0]    <= '0;
      st_p[0][0] <= flip[0];
      for (int s = 1; s < NGRP; s++) begin
        st_v[s]    <= st_v[s-1];
        st_w[s]    <= st_w[s-1] ^ fmask[s];
        st_p[s]    <= st_p[s-1];
        st_p[s][s] <= flip[s];
      end
    end
  end

  assign out_valid = st_v[NGRP-1];
  assign out_wires = st_w[NGRP-1];
  assign out_pol   = st_p[NGRP-1];
endmodule

// File: rtl/xtc_decoder.sv
module xtc_decoder
  import xtc_pkg::*;
#(
  parameter int NGRP = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [NGRP*CODE_W-1:0] in_wires,
  input  logic [NGRP-1:0]        in_pol,
  output logic                   out_valid,
  output logic [NGRP*GRP_W-1:0]  out_data
);
  logic [NGRP*GRP_W-1:0] dec_comb;

  for (genvar g = 0; g < NGRP; g++) begin : g_inv
    assign dec_comb[g*GRP_W +: GRP_W] =
      grp_decode(in_wires[g*CODE_W +: CODE_W] ^ {CODE_W{in_pol[g]}});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      out_data  <= dec_comb;
    end
  end
endmodule

// File: rtl/xtc_codec.sv
module xtc_codec
  import xtc_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int NGRP  = DATA_W / GRP_W,
  localparam int BUS_W = NGRP * CODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              bus_valid,
  output logic [BUS_W-1:0]  bus_wires,
  output logic [NGRP-1:0]   bus_pol,
  output logic              dec_valid,
  output logic [DATA_W-1:0] dec_data
);
  xtc_encoder #(.NGRP(NGRP)) u_enc (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .out_valid (bus_valid),
    .out_wires (bus_wires),
    .out_pol   (bus_pol)
  );

  xtc_decoder #(.NGRP(NGRP)) u_dec (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (bus_valid),
    .in_wires  (bus_wires),
    .in_pol    (bus_pol),
    .out_valid (dec_valid),
    .out_data  (dec_data)
  );
endmodule

// File: rtl/xtc_codec_chk.sv
module xtc_codec_chk
  import xtc_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int NGRP  = DATA_W / GRP_W,
  localparam int BUS_W = NGRP * CODE_W
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              bus_valid,
  input logic [BUS_W-1:0]  bus_wires,
  input logic [NGRP-1:0]   bus_pol,
  input logic              dec_valid,
  input logic [DATA_W-1:0] dec_data
);
  function automatic logic bus_clean(input logic [BUS_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < BUS_W - 2; i++)
      if (w[i +: 3] == 3'b010 || w[i +: 3] == 3'b101) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic edges_match(input logic [BUS_W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int g = 1; g < NGRP; g++)
      if (w[g*CODE_W] != w[g*CODE_W-1]) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic groups_in_book(input logic [BUS_W-1:0] w,
                                          input logic [NGRP-1:0] p);
    logic ok;
    ok = 1'b1;
    for (int g = 0; g < NGRP; g++)
      if (!win_clean5(w[g*CODE_W +: CODE_W] ^ {CODE_W{p[g]}})) ok = 1'b0;
    return ok;
  endfunction

  AST_GROUP_IN_BOOK: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> groups_in_book(bus_wires, bus_pol)); // R1
  AST_NO_FORBIDDEN: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> bus_clean(bus_wires)); // R2
  AST_GRP0_TRUE: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> !bus_pol[0]); // R3
  AST_EDGE_REPEAT: assert property (@(posedge clk) disable iff (rst)
    bus_valid |-> edges_match(bus_wires)); // R4
  AST_DEC_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    $past(bus_valid) |-> dec_valid); // R6
  AST_DEC_NO_EXTRA: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_valid) |-> !dec_valid); // R6
endmodule

bind xtc_codec xtc_codec_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .bus_valid (bus_valid),
  .bus_wires (bus_wires),
  .bus_pol   (bus_pol),
  .dec_valid (dec_valid),
  .dec_data  (dec_data)
);

// File: tb/tb_xtc_codec.sv
`timescale 1ns/1ps
module tb_xtc_codec;
  localparam int DATA_W = 16;
  localparam int NGRP   = DATA_W / 4;
  localparam int BUS_W  = NGRP * 5;
  localparam int WDOG   = 100000;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic [DATA_W-1:0] in_data;
  logic              bus_valid;
  logic [BUS_W-1:0]  bus_wires;
  logic [NGRP-1:0]   bus_pol;
  logic              dec_valid;
  logic [DATA_W-1:0] dec_data;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  typedef struct packed {
    logic [BUS_W-1:0]  w;
    logic [NGRP-1:0]   p;
    logic [DATA_W-1:0] d;
    int                t;
  } item_t;

  item_t enc_q[$];
  item_t dec_q[$];

  xtc_codec #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .bus_valid(bus_valid), .bus_wires(bus_wires), .bus_pol(bus_pol),
    .dec_valid(dec_valid), .dec_data(dec_data)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Code book of R1, written out as a table.
  function automatic logic [4:0] book(input logic [3:0] v);
    case (v)
      4'd0:  return 5'b00000;  4'd1:  return 5'b00001;
      4'd2:  return 5'b00011;  4'd3:  return 5'b00110;
      4'd4:  return 5'b00111;  4'd5:  return 5'b01100;
      4'd6:  return 5'b01110;  4'd7:  return 5'b01111;
      4'd8:  return 5'b10000;  4'd9:  return 5'b10001;
      4'd10: return 5'b10011;  4'd11: return 5'b11000;
      4'd12: return 5'b11001;  4'd13: return 5'b11100;
      4'd14: return 5'b11110;  default: return 5'b11111;
    endcase
  endfunction

  function automatic item_t model(input logic [DATA_W-1:0] d, input int t);
    item_t it;
    logic [4:0] c;
    it.w = '0; it.p = '0; it.d = d; it.t = t;
    for (int g = 0; g < NGRP; g++) begin
      c = book(d[g*4 +: 4]);
      if (g > 0 && c[0] != it.w[g*5-1]) begin
        c = ~c;
        it.p[g] = 1'b1;
      end
      it.w[g*5 +: 5] = c;
    end
    return it;
  endfunction

  function automatic logic scan_ok(input logic [BUS_W-1:0] w);
    for (int i = 0; i + 2 < BUS_W; i++)
      if (w[i +: 3] == 3'b010 || w[i +: 3] == 3'b101) return 1'b0;
    return 1'b1;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic send(input logic v, input logic [DATA_W-1:0] d);
    @(negedge clk);
    in_valid = v;
    in_data  = d;
    if (v) begin
      enc_q.push_back(model(d, cyc + 1));
      dec_q.push_back(model(d, cyc + 1));
    end
  endtask

  // Monitor: compares each produced result with the queued expectation.
  always @(negedge clk) begin
    if (!rst) begin
      if (bus_valid) begin
        if (enc_q.size() == 0) chk(1'b0, "R8", "unexpected bus word", 64'(bus_wires), 0);
        else begin
          item_t e;
          e = enc_q.pop_front();
          chk(bus_wires == e.w, "R1_R4", "bus wires", 64'(bus_wires), 64'(e.w));
          chk(bus_pol == e.p, "R3_R4", "polarity", 64'(bus_pol), 64'(e.p));
          chk(cyc == e.t + NGRP - 1, "R5", "encode latency", 64'(cyc), 64'(e.t + NGRP - 1));
          chk(scan_ok(bus_wires), "R2", "forbidden window", 64'(bus_wires), 0);
        end
      end
      if (dec_valid) begin
        if (dec_q.size() == 0) chk(1'b0, "R8", "unexpected decode", 64'(dec_data), 0);
        else begin
          item_t e;
          e = dec_q.pop_front();
          chk(dec_data == e.d, "R6", "decoded data", 64'(dec_data), 64'(e.d));
          chk(cyc == e.t + NGRP, "R6", "decode latency", 64'(cyc), 64'(e.t + NGRP));
        end
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > WDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    repeat (5) @(negedge clk);
    // R7: reset state of all outputs
    chk(!bus_valid && !dec_valid, "R7", "valids in reset", {62'd0, bus_valid, dec_valid}, 0);
    chk(bus_wires == '0 && bus_pol == '0, "R7", "bus in reset", 64'(bus_wires), 0);
    chk(dec_data == '0, "R7", "dec data in reset", 64'(dec_data), 0);
    rst = 1'b0;

    // Every group value copied into every group (R1, R4)
    for (int v = 0; v < 16; v++) begin
      logic [DATA_W-1:0] d;
      for (int g = 0; g < NGRP; g++) d[g*4 +: 4] = 4'(v);
      send(1'b1, d);
    end
    // All pairs across the lowest boundary, upper groups varying (R4, R5)
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        send(1'b1, DATA_W'({a[3:0], b[3:0], b[3:0], a[3:0]}));
    // Random words with idle gaps and junk data on idle cycles (R5, R8)
    for (int i = 0; i < 600; i++)
      send(($urandom % 3) != 0, DATA_W'($urandom));
    for (int i = 0; i < NGRP + 4; i++) send(1'b0, DATA_W'($urandom));
    chk(enc_q.size() == 0, "R5", "encoder words lost", 64'(enc_q.size()), 0);
    chk(dec_q.size() == 0, "R6", "decoder words lost", 64'(dec_q.size()), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule